// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block watches the left/right (frame) clock of an audio interface from inside the master clock domain. It counts how many master clock cycles separate two rising frame edges and matches that count against the six supported ratios: 128, 192, 256, 384, 512 and 768. Once a ratio is confirmed, it reports a ratio code and a valid flag. From the same ratio it selects the oversampling rate for the playback (DAC) path and for the capture (ADC) path.

The two lowest ratios are the only ones that fit the fastest sample-rate class. At those ratios the playback path drops from 128fs to 64fs, and the capture path raises an error because it cannot run there. Otherwise the capture path runs at 128fs, or at 64fs when software sets the reduced-oversampling request. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `audio_ratio_detect`

## Requirements
- R1: While reset is held and right after it is released, ratio_code is 7 and ratio_valid, dac_osr_64, adc_osr_64 and adc_ratio_err are all 0, even when adc_half_osr_req is 1.
- R2: The ratio code is 0, 1, 2, 3, 4 or 5 for the ratios 128, 192, 256, 384, 512 and 768, and 7 for unknown. ratio_valid is 1 exactly when the code is in the range 0 to 5.
- R3: A period is the number of master clock cycles between two successive rising edges of lrclk, taken after a two-flop synchronizer. A period within ±2 cycles of a supported ratio is classified as that ratio.
- R4: dac_osr_64 is 1 when a valid ratio of 128 or 192 is reported, and 0 (128fs) in every other case.
- R5: adc_ratio_err is 1 when a valid ratio of 128 or 192 is reported. adc_osr_64 equals adc_half_osr_req in the same cycle when a valid ratio without error is reported, and is 0 otherwise.
- R6: A new ratio is reported only after two consecutive periods give the same class. A single differing period leaves the output unchanged, and so does the first period after reset.
- R7: A period that falls outside every tolerance window sets the code to 7 and clears ratio_valid after that one period.
- R8: If lrclk has no rising edge for 771 master cycles (largest ratio + tolerance + 1), the result is treated as an unknown period (R7).
- R9: Take the first master edge that samples lrclk high. The rising frame edge that closes a deciding period updates ratio_code on the fourth master edge counted from that one (three register stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk_in | input | 1 | Left/right frame clock, asynchronous to clk_mclk |
| adc_half_osr_req | input | 1 | Software request for 64fs capture oversampling (clk_mclk domain) |
| ratio_code | output | 3 | Confirmed ratio: 0..5 = 128,192,256,384,512,768; 7 = unknown |
| ratio_valid | output | 1 | A supported ratio is confirmed |
| dac_osr_64 | output | 1 | Playback path runs at 64fs (0 = 128fs) |
| adc_osr_64 | output | 1 | Capture path runs at 64fs (0 = 128fs) |
| adc_ratio_err | output | 1 | Confirmed ratio is not usable by the capture path |

## Verification
A frame edge that the bench drives between clock edges reaches ratio_code and ratio_valid on the fourth master edge counted from the edge that samples it. The latency test samples one cycle before that edge and expects the old code, then samples one cycle after it and expects the new code. All other ratio checks sample eight cycles after the closing edge, which is well inside the next period. The oversampling and error pins are decoded from registered state and the software request without further registers, so they are checked one cycle after the request changes. The timeout case is sampled 900 cycles after the last edge, which is beyond the 771-cycle limit plus pipeline.

// File: rtl/ard_pkg.sv
package ard_pkg;

  typedef logic [2:0] ratio_code_t;

  localparam int          NUM_RATIO    = 6;
  localparam ratio_code_t CODE_UNKNOWN = 3'd7;

  // Multipliers of the base unit (64) giving 128,192,256,384,512,768.
  function automatic int ratio_mult(input int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return 6;
      4:       return 8;
      default: return 12;
    endcase
  endfunction

  function automatic int nominal_ratio(input int idx, input int base);
    return ratio_mult(idx) * base;
  endfunction

  // Codes at or below this index belong to the fast sample-rate class.
  localparam ratio_code_t LAST_FAST_CODE = 3'd1;

endpackage

// File: rtl/ard_lr_sync.sv
module ard_lr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_pulse = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ard_period_count.sv
module ard_period_count #(
  parameter int CNT_W     = 10,
  parameter int CNT_LIMIT = 771
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_seen,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_cnt,
  output logic [CNT_W-1:0] run_cnt
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(CNT_LIMIT);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit_limit;

  assign hit_limit = (cnt_q == LIMIT_V - 1'b1) && !edge_seen;
  assign run_cnt   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      meas_vld <= 1'b0;
      meas_cnt <= '0;
    end else begin
      meas_vld <= 1'b0;
      if (edge_seen) begin
        armed_q <= 1'b1;
        cnt_q   <= CNT_W'(1);
        if (armed_q && cnt_q != LIMIT_V) begin
          meas_vld <= 1'b1;
          meas_cnt <= cnt_q;
        end
      end else if (cnt_q != LIMIT_V) begin
        cnt_q <= cnt_q + 1'b1;
        if (hit_limit) begin
          meas_vld <= 1'b1;
          meas_cnt <= LIMIT_V;
        end
      end
    end
  end
endmodule

// File: rtl/ard_ratio_class.sv
module ard_ratio_class #(
  parameter int CNT_W = 10,
  parameter int BASE  = 64,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0]      meas_cnt,
  output ard_pkg::ratio_code_t  class_code
);
  logic [ard_pkg::NUM_RATIO-1:0] hit;

  for (genvar g = 0; g < ard_pkg::NUM_RATIO; g++) begin : g_win
    localparam int               NOM = ard_pkg::nominal_ratio(g, BASE);
    localparam logic [CNT_W-1:0] LO  = CNT_W'(NOM - TOL);
    localparam logic [CNT_W-1:0] HI  = CNT_W'(NOM + TOL);
    assign hit[g] = (meas_cnt >= LO) && (meas_cnt <= HI);
  end

  always_comb begin
    class_code = ard_pkg::CODE_UNKNOWN;
    for (int i = ard_pkg::NUM_RATIO - 1; i >= 0; i--) begin
      if (hit[i]) class_code = 3'(i);
    end
  end
endmodule

// File: rtl/ard_confirm.sv
module ard_confirm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 meas_vld,
  input  ard_pkg::ratio_code_t class_code,
  output ard_pkg::ratio_code_t code_q,
  output logic                 valid_q
);
  ard_pkg::ratio_code_t pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= ard_pkg::CODE_UNKNOWN;
      code_q  <= ard_pkg::CODE_UNKNOWN;
      valid_q <= 1'b0;
    end else if (meas_vld) begin
      pend_q <= class_code;
      if (class_code == ard_pkg::CODE_UNKNOWN) begin
        code_q  <= ard_pkg::CODE_UNKNOWN;
        valid_q <= 1'b0;
      end else if (class_code == pend_q) begin
        code_q  <= class_code;
        valid_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_ratio_detect.sv
module audio_ratio_detect #(
  parameter int BASE        = 64,
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_mclk,
  input  logic       rst_n,
  input  logic       lrclk_in,
  input  logic       adc_half_osr_req,
  output logic [2:0] ratio_code,
  output logic       ratio_valid,
  output logic       dac_osr_64,
  output logic       adc_osr_64,
  output logic       adc_ratio_err
);
  localparam int CNT_LIMIT =
    ard_pkg::nominal_ratio(ard_pkg::NUM_RATIO - 1, BASE) + TOL + 1;
  localparam int CNT_W = $clog2(CNT_LIMIT + 1);

  logic                 lr_rise;
  logic                 meas_vld;
  logic [CNT_W-1:0]     meas_cnt;
  logic [CNT_W-1:0]     run_cnt;
  ard_pkg::ratio_code_t class_code;
  ard_pkg::ratio_code_t code_q;
  logic                 valid_q;
  logic                 fast_class;

  ard_lr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk_mclk),
    .rst_n      (rst_n),
    .async_in   (lrclk_in),
    .rise_pulse (lr_rise)
  );

  ard_period_count #(.CNT_W(CNT_W), .CNT_LIMIT(CNT_LIMIT)) u_cnt (
    .clk       (clk_mclk),
    .rst_n     (rst_n),
    .edge_seen (lr_rise),
    .meas_vld  (meas_vld),
    .meas_cnt  (meas_cnt),
    .run_cnt   (run_cnt)
  );

  ard_ratio_class #(.CNT_W(CNT_W), .BASE(BASE), .TOL(TOL)) u_class (
    .meas_cnt   (meas_cnt),
    .class_code (class_code)
  );

  ard_confirm u_conf (
    .clk        (clk_mclk),
    .rst_n      (rst_n),
    .meas_vld   (meas_vld),
    .class_code (class_code),
    .code_q     (code_q),
    .valid_q    (valid_q)
  );

  assign fast_class    = valid_q && (code_q <= ard_pkg::LAST_FAST_CODE);
  assign ratio_code    = code_q;
  assign ratio_valid   = valid_q;
  assign dac_osr_64    = fast_class;
  assign adc_ratio_err = fast_class;
  assign adc_osr_64    = valid_q && !fast_class && adc_half_osr_req;
endmodule

// File: rtl/ard_checker.sv
module ard_checker #(
  parameter int CNT_W     = 10,
  parameter int CNT_LIMIT = 771
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       ratio_code,
  input logic             ratio_valid,
  input logic             dac_osr_64,
  input logic             adc_osr_64,
  input logic             adc_ratio_err,
  input logic             meas_vld,
  input logic [CNT_W-1:0] run_cnt
);
  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid |-> (ratio_code <= 3'd5));

  p_unknown_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_valid |-> (ratio_code == 3'd7));

  p_dac_err_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_osr_64 == adc_ratio_err);

  p_err_blocks_osr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ratio_err |-> !adc_osr_64);

  p_change_after_meas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code != $past(ratio_code)) |-> $past(meas_vld));

  p_valid_after_meas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid) |-> $past(meas_vld));

  p_cnt_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(CNT_LIMIT));
endmodule

bind audio_ratio_detect ard_checker #(.CNT_W(CNT_W), .CNT_LIMIT(CNT_LIMIT)) u_chk (
  .clk           (clk_mclk),
  .rst_n         (rst_n),
  .ratio_code    (ratio_code),
  .ratio_valid   (ratio_valid),
  .dac_osr_64    (dac_osr_64),
  .adc_osr_64    (adc_osr_64),
  .adc_ratio_err (adc_ratio_err),
  .meas_vld      (meas_vld),
  .run_cnt       (run_cnt)
);

// File: tb/test_audio_ratio_detect.sv
module test_audio_ratio_detect;
  logic       clk_mclk = 1'b0;
  logic       rst_n    = 1'b0;
  logic       lrclk_in = 1'b0;
  logic       adc_req  = 1'b0;
  logic [2:0] ratio_code;
  logic       ratio_valid, dac_osr_64, adc_osr_64, adc_ratio_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk_mclk = ~clk_mclk;

  audio_ratio_detect i_audio_ratio_detect (
    .clk_mclk         (clk_mclk),
    .rst_n            (rst_n),
    .lrclk_in         (lrclk_in),
    .adc_half_osr_req (adc_req),
    .ratio_code       (ratio_code),
    .ratio_valid      (ratio_valid),
    .dac_osr_64       (dac_osr_64),
    .adc_osr_64       (adc_osr_64),
    .adc_ratio_err    (adc_ratio_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_status(string req, int code, int vld);
    chk(req, "ratio_code", int'(ratio_code), code);
    chk(req, "ratio_valid", int'(ratio_valid), vld);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lrclk_in = 1'b0;
    repeat (4) @(negedge clk_mclk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_mclk);
  endtask

  // k rising frame edges spaced by len master cycles
  task automatic run(int len, int k);
    for (int i = 0; i < k; i++) begin
      lrclk_in = 1'b1;
      repeat (len / 2) @(negedge clk_mclk);
      lrclk_in = 1'b0;
      repeat (len - len / 2) @(negedge clk_mclk);
    end
  endtask

  // One rising edge that closes the running period; check after 8 cycles,
  // then hold so that the next period lasts len cycles.
  task automatic close(int len, int code, int vld, string req);
    lrclk_in = 1'b1;
    repeat (8) @(negedge clk_mclk);
    chk_status(req, code, vld);
    repeat (len / 2 - 8) @(negedge clk_mclk);
    lrclk_in = 1'b0;
    repeat (len - len / 2) @(negedge clk_mclk);
  endtask

  task automatic test_reset();
    adc_req = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk_mclk);
    chk_status("R1", 7, 0);
    rst_n = 1'b1;
    @(negedge clk_mclk);
    chk_status("R1", 7, 0);
    chk("R1", "dac_osr_64", int'(dac_osr_64), 0);
    chk("R1", "adc_osr_64", int'(adc_osr_64), 0);
    chk("R1", "adc_ratio_err", int'(adc_ratio_err), 0);
    adc_req = 1'b0;
  endtask

  task automatic test_all_ratios();
    int nom [6] = '{128, 192, 256, 384, 512, 768};
    for (int i = 0; i < 6; i++) begin
      do_reset();
      run(nom[i], 2);
      close(nom[i], i, 1, "R2 R3");
      chk("R4", "dac_osr_64", int'(dac_osr_64), (i <= 1) ? 1 : 0);
      chk("R5", "adc_ratio_err", int'(adc_ratio_err), (i <= 1) ? 1 : 0);
    end
  endtask

  task automatic test_switch_latency();
    do_reset();
    run(256, 1);
    close(256, 7, 0, "R6 first period");
    close(256, 2, 1, "R6 second period");
    run(384, 1);
    close(384, 2, 1, "R6 single differing period");
    lrclk_in = 1'b1;
    repeat (3) @(negedge clk_mclk);
    chk("R9", "code before due edge", int'(ratio_code), 2);
    @(negedge clk_mclk);
    chk("R9", "code at due edge", int'(ratio_code), 3);
    chk("R9", "valid at due edge", int'(ratio_valid), 1);
    repeat (188) @(negedge clk_mclk);
    lrclk_in = 1'b0;
    repeat (192) @(negedge clk_mclk);
  endtask

  task automatic test_tolerance();
    do_reset();
    run(514, 2);
    close(514, 4, 1, "R3 +2");
    run(382, 1);
    close(382, 4, 1, "R6 one 382 period");
    close(515, 3, 1, "R3 -2");
    close(256, 7, 0, "R7 515 rejected");
    close(256, 7, 0, "R6 recover first");
    close(256, 2, 1, "R6 recover second");
  endtask

  task automatic test_adc_select();
    do_reset();
    adc_req = 1'b1;
    run(256, 2);
    close(256, 2, 1, "R5");
    chk("R5", "adc_osr_64 req=1", int'(adc_osr_64), 1);
    chk("R4", "dac_osr_64 at 256", int'(dac_osr_64), 0);
    adc_req = 1'b0;
    @(negedge clk_mclk);
    chk("R5", "adc_osr_64 req=0", int'(adc_osr_64), 0);
    adc_req = 1'b1;
    do_reset();
    run(192, 2);
    close(192, 1, 1, "R5");
    chk("R5", "adc_ratio_err at 192", int'(adc_ratio_err), 1);
    chk("R5", "adc_osr_64 blocked", int'(adc_osr_64), 0);
    chk("R4", "dac_osr_64 at 192", int'(dac_osr_64), 1);
    adc_req = 1'b0;
  endtask

  task automatic test_timeout();
    do_reset();
    run(384, 2);
    close(900, 3, 1, "R8 before stop");
    chk_status("R8", 7, 0);
    chk("R8", "dac_osr_64", int'(dac_osr_64), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_mclk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    test_reset();
    test_all_ratios();
    test_switch_latency();
    test_tolerance();
    test_adc_select();
    test_timeout();
    finish_run();
  end
endmodule